// File: doc/BRIEF.md
# Serial Audio Transmitter with FIFO Status

This block drives a three-wire serial audio link as the clock master. Software pushes 16-bit samples into a small transmit queue through a register port. The block shifts them out, MSB first, as alternating left and right channel words of 16 bit periods each. It produces the bit clock, the channel select line and the serial data.

A configuration word holds these controls:
- a held soft reset
- a queue enable
- a master-run switch
- the framing format
- a size field, which is read back only
- the interrupt enable

A second word reports how many queue slots are free. It also holds the interrupt threshold and a one-shot queue flush. The interrupt line tells software that the queue has room, so it can refill in bursts.

Framing follows one of two formats. In standard framing, the channel select changes one bit period before the MSB of each word. In left-justified framing, it changes together with the MSB. When the queue runs dry, the link keeps clocking and sends zero words.

Top module: `pcm_serial_tx`

## Requirements
- R1: After the synchronous reset, all four serial and interrupt outputs are low, the configuration word reads 0, and the status word reads `FIFO_DEPTH` (16) in bits [21:16] and zero elsewhere.
- R2: A write to address 0 stores these configuration bits, which read back in the same places:
  - bit 31: soft reset
  - bit 29: queue enable
  - bit 25: master run
  - bits [11:10]: format
  - bits [9:8]: size
  - bit 1: interrupt enable

  All other bits read 0. Read data appears one clock after the address is presented. Address 1 returns the status word, and address 2 reads 0.
- R3: A write to address 2 pushes bits [15:0] into the 16-entry queue only when bit 29 is 1, bit 31 is 0 and the queue is not full. Otherwise the write is dropped. Address 1 bits [21:16] give 16 minus the occupancy.
- R4: Writing address 1 with bit 8 set empties the queue in that clock, and bit 8 always reads 0. While configuration bit 31 is 1, the queue is held empty and the serial outputs are held idle.
- R5: The link runs while bit 25 is 1 and bit 31 is 0. The bit clock starts low and toggles every `BCLK_DIV` clocks. When the link is not running, the bit clock, channel select and data are all low, and the next frame starts afresh.
- R6: A frame is 32 bit periods long. Data and channel select change only on the clock in which the bit clock falls. The left word is sent first, with the channel select low, and it is the older queue entry. Each word is sent MSB first.
- R7: With bit 11 at 0 (format code 0), channel select changes one bit period before each word's MSB. With bit 11 at 1 (format code 2), it changes together with the MSB.
- R8: When a word starts while the queue is empty, or while bit 29 is 0, a zero word is sent. The queue is left untouched, and the bit clock keeps running.
- R9: The interrupt output is registered from the previous clock's state. It is high when bit 1 is set and the free count is at least 4 times the code in address 1 bits [1:0]. That means 4, 8 or 12 slots for codes 1, 2 and 3, and always for code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 configuration, 1 status, 2 sample push |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Channel select, low for left |
| sd_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | Queue-has-room interrupt |

## Verification
The hardest states to reach from the ports are the queue boundaries while the serializer is pulling words:
- a full queue that refuses a push
- a queue that empties in the middle of a frame
- a running link with the queue disabled while entries are still stored

The stimulus fills the queue past its depth while the link is stopped, then starts the link and lets it drain into underflow in both framings. It then disables the queue with entries still present, and it flushes the queue by both the one-shot control and the held soft reset. A behavioural model in the bench tracks every clock and compares all outputs and the read data.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int FREE_W   = 6;
  localparam int LVL_STEP = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PUSH = 2'd2;

  localparam int CFG_SRST_BIT = 31;
  localparam int CFG_TXEN_BIT = 29;
  localparam int CFG_MST_BIT  = 25;
  localparam int CFG_FMT_LSB  = 10;
  localparam int CFG_SIZE_LSB = 8;
  localparam int CFG_IEN_BIT  = 1;
  localparam int ST_FREE_LSB  = 16;
  localparam int ST_FLUSH_BIT = 8;

  typedef struct packed {
    logic       srst;
    logic       txen;
    logic       master;
    logic [1:0] fmt;
    logic [1:0] size;
    logic       ien;
  } cfg_t;
endpackage

// File: rtl/pcm_tx_regs.sv
module pcm_tx_regs
  import pcm_tx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic [CNT_W-1:0]    fifo_count,
  output cfg_t                cfg_o,
  output logic                push_o,
  output logic                flush_o,
  output logic [SAMPLE_W-1:0] push_data_o,
  output logic [BUS_W-1:0]    rdata_o,
  output logic                irq_o
);
  cfg_t             cfg_q;
  logic [1:0]       thr_q;
  logic [CNT_W-1:0] free_w;
  logic [BUS_W-1:0] rd_word;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata;
  assign free_w       = CNT_W'(DEPTH) - fifo_count;
  assign cfg_o        = cfg_q;
  assign push_data_o  = bus_wdata[SAMPLE_W-1:0];
  assign push_o       = bus_wr && (bus_addr == ADDR_PUSH) && cfg_q.txen && !cfg_q.srst;
  assign flush_o      = (bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[ST_FLUSH_BIT]) || cfg_q.srst;

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_CFG) begin
      rd_word[CFG_SRST_BIT]            = cfg_q.srst;
      rd_word[CFG_TXEN_BIT]            = cfg_q.txen;
      rd_word[CFG_MST_BIT]             = cfg_q.master;
      rd_word[CFG_FMT_LSB +: 2]        = cfg_q.fmt;
      rd_word[CFG_SIZE_LSB +: 2]       = cfg_q.size;
      rd_word[CFG_IEN_BIT]             = cfg_q.ien;
    end else if (bus_addr == ADDR_STAT) begin
      rd_word[ST_FREE_LSB +: FREE_W]   = FREE_W'(free_w);
      rd_word[1:0]                     = thr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      thr_q   <= '0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_word;
      irq_o   <= cfg_q.ien && (int'(free_w) >= int'(thr_q) * LVL_STEP);
      if (bus_wr && bus_addr == ADDR_CFG) begin
        cfg_q.srst   <= bus_wdata[CFG_SRST_BIT];
        cfg_q.txen   <= bus_wdata[CFG_TXEN_BIT];
        cfg_q.master <= bus_wdata[CFG_MST_BIT];
        cfg_q.fmt    <= bus_wdata[CFG_FMT_LSB +: 2];
        cfg_q.size   <= bus_wdata[CFG_SIZE_LSB +: 2];
        cfg_q.ien    <= bus_wdata[CFG_IEN_BIT];
      end
      if (bus_wr && bus_addr == ADDR_STAT)
        thr_q <= bus_wdata[1:0];
    end
  end

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.ien |=> !irq_o);
endmodule

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign push_ok = push && !full_o && !flush;
  assign pop_ok  = pop && !empty_o && !flush;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count_o <= count_o + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_o == '0));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full_o && !pop && !flush) |=> (count_o == $past(count_o)));
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int SAMPLE_W = 16,
  parameter int BCLK_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                left_just,
  input  logic                fifo_en,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_head,
  output logic                fifo_pop,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int SLOT_N = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int DIV_W  = (BCLK_DIV > 1) ? $clog2(BCLK_DIV) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_N - 1);
  localparam logic [SLOT_W-1:0] HALF      = SLOT_W'(SAMPLE_W);
  localparam logic [SLOT_W-1:0] PRE_HALF  = SLOT_W'(SAMPLE_W - 1);
  localparam logic [SLOT_W-1:0] PRE_LAST  = SLOT_W'(SLOT_N - 2);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(BCLK_DIV - 1);

  logic [DIV_W-1:0]    div_q;
  logic [SLOT_W-1:0]   slot_q, nslot;
  logic [SAMPLE_W-1:0] sh_q, word;
  logic                tick, fall, load, ws_next;

  assign tick     = active && (div_q == DIV_LAST);
  assign fall     = tick && bclk_o;
  assign nslot    = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
  assign load     = fall && ((nslot == '0) || (nslot == HALF));
  assign fifo_pop = load && fifo_en && !fifo_empty;
  assign word     = fifo_pop ? fifo_head : '0;
  assign ws_next  = left_just ? (nslot >= HALF)
                              : ((nslot >= PRE_HALF) && (nslot <= PRE_LAST));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      div_q  <= '0;
      bclk_o <= 1'b0;
      slot_q <= SLOT_LAST;
      ws_o   <= 1'b0;
      sd_o   <= 1'b0;
      sh_q   <= '0;
    end else begin
      if (tick) begin
        div_q  <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        div_q  <= div_q + 1'b1;
      end
      if (fall) begin
        slot_q <= nslot;
        ws_o   <= ws_next;
        if (load) begin
          sd_o <= word[SAMPLE_W-1];
          sh_q <= {word[SAMPLE_W-2:0], 1'b0};
        end else begin
          sd_o <= sh_q[SAMPLE_W-1];
          sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
        end
      end
    end
  end

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!bclk_o && !ws_o && !sd_o));
  // R6
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$stable(ws_o)) |-> $fell(bclk_o));
  // R6
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$stable(sd_o)) |-> $fell(bclk_o));
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int BCLK_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  cfg_t                cfg;
  logic                push, flush, pop, empty, full;
  logic [SAMPLE_W-1:0] push_data, head;
  logic [CNT_W-1:0]    count;
  logic                full_unused;

  assign full_unused = full;

  pcm_tx_regs #(.DEPTH(FIFO_DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .fifo_count(count), .cfg_o(cfg), .push_o(push),
    .flush_o(flush), .push_data_o(push_data), .rdata_o(bus_rdata), .irq_o(irq_o)
  );

  pcm_tx_fifo #(.DATA_W(SAMPLE_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
    .flush(flush), .head_o(head), .count_o(count), .empty_o(empty), .full_o(full)
  );

  pcm_tx_serializer #(.SAMPLE_W(SAMPLE_W), .BCLK_DIV(BCLK_DIV)) u_ser (
    .clk(clk), .rst(rst), .active(cfg.master && !cfg.srst), .left_just(cfg.fmt[1]),
    .fifo_en(cfg.txen), .fifo_empty(empty), .fifo_head(head), .fifo_pop(pop),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );
endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DIV   = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bclk_o, ws_o, sd_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  pcm_serial_tx #(.SAMPLE_W(16), .FIFO_DEPTH(DEPTH), .BCLK_DIV(DIV)) i_pcm_serial_tx (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_srst, m_en, m_mst, m_ien, m_bclk, m_ws, m_sd, m_irq;
  bit [1:0] m_fmt, m_size, m_thr;
  int m_div, m_slot, m_sh;
  logic [31:0] m_rd;
  int q[$];

  always @(posedge clk) begin : model
    int pre_n, nslot, smp;
    bit act, flush, wr_ok, irq_n;
    if (rst) begin
      m_srst = 0; m_en = 0; m_mst = 0; m_ien = 0; m_fmt = 0; m_size = 0; m_thr = 0;
      m_bclk = 0; m_ws = 0; m_sd = 0; m_irq = 0; m_div = 0; m_slot = 31; m_sh = 0;
      m_rd = 0; q.delete();
    end else begin
      pre_n = q.size();
      if (bus_addr == 0)
        m_rd = (32'(m_srst) << 31) | (32'(m_en) << 29) | (32'(m_mst) << 25) |
               (32'(m_fmt) << 10) | (32'(m_size) << 8) | (32'(m_ien) << 1);
      else if (bus_addr == 1)
        m_rd = (32'(DEPTH - pre_n) << 16) | 32'(m_thr);
      else
        m_rd = 0;
      irq_n = m_ien && ((DEPTH - pre_n) >= 4 * m_thr);
      wr_ok = bus_wr && bus_addr == 2 && m_en && !m_srst && pre_n < DEPTH;
      flush = (bus_wr && bus_addr == 1 && bus_wdata[8]) || m_srst;
      act = m_mst && !m_srst;
      if (!act) begin
        m_div = 0; m_bclk = 0; m_slot = 31; m_ws = 0; m_sd = 0; m_sh = 0;
      end else if (m_div == DIV - 1) begin
        m_div = 0;
        if (m_bclk) begin
          nslot = (m_slot + 1) % 32;
          m_slot = nslot;
          if (nslot % 16 == 0) begin
            smp = (m_en && q.size() > 0) ? q.pop_front() : 0;
            m_sd = smp[15];
            m_sh = (smp << 1) & 16'hFFFF;
          end else begin
            m_sd = m_sh[15];
            m_sh = (m_sh << 1) & 16'hFFFF;
          end
          m_ws = m_fmt[1] ? (nslot >= 16) : (((nslot + 1) % 32) >= 16);
        end
        m_bclk = !m_bclk;
      end else begin
        m_div++;
      end
      if (flush) q.delete();
      else if (wr_ok) q.push_back(int'(bus_wdata[15:0]));
      if (bus_wr && bus_addr == 0) begin
        m_srst = bus_wdata[31]; m_en = bus_wdata[29]; m_mst = bus_wdata[25];
        m_fmt = bus_wdata[11:10]; m_size = bus_wdata[9:8]; m_ien = bus_wdata[1];
      end
      if (bus_wr && bus_addr == 1) m_thr = bus_wdata[1:0];
      m_irq = irq_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 bit clock", {31'b0, bclk_o}, {31'b0, m_bclk});
      chk("R7 channel select", {31'b0, ws_o}, {31'b0, m_ws});
      chk("R6 serial data", {31'b0, sd_o}, {31'b0, m_sd});
      chk("R9 interrupt", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R2 read data", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] samp(input int i);
    return 32'(16'(32'hA5C3 + i * 32'h1357));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ones, rises;
    bit prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs idle", {28'b0, bclk_o, ws_o, sd_o, irq_o}, 32'h0);
    rd(1, v); chk("R1 status after reset", v, 32'h0010_0000);
    rd(0, v); chk("R1 config after reset", v, 32'h0);
    // R2 readback mask
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 config readback", v, 32'hA200_0F02);
    wr(0, 32'h0);
    // R3 overfill while stopped
    wr(0, 32'h2000_0000);
    for (int i = 0; i < 18; i++) wr(2, samp(i));
    rd(1, v); chk("R3 free count when full", {26'b0, v[21:16]}, 32'd0);
    // R9 threshold 12 with full queue
    wr(1, 32'h3); wr(0, 32'h2000_0002); idle(2);
    chk("R9 irq low when full", {31'b0, irq_o}, 32'd0);
    // standard framing drain
    wr(0, 32'h2200_0002);
    idle(128 * 7);
    chk("R9 irq high after drain", {31'b0, irq_o}, 32'd1);
    idle(128 * 2);
    // R8 underflow: zeros, clock running
    ones = 0; rises = 0; prev = bclk_o;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (sd_o) ones++;
      if (bclk_o && !prev) rises++;
      prev = bclk_o;
    end
    chk("R8 zero data on underflow", 32'(ones), 32'd0);
    chk("R8 bit clock keeps running", 32'(rises), 32'd64);
    // R7 left-justified framing
    wr(0, 32'h2200_0802);
    for (int i = 0; i < 6; i++) wr(2, samp(i + 40));
    idle(128 * 4);
    // R8 queue disabled with entries stored
    wr(0, 32'h2000_0800);
    for (int i = 0; i < 4; i++) wr(2, samp(i + 60));
    wr(0, 32'h0200_0800);
    ones = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (sd_o) ones++;
    end
    chk("R8 zeros while queue disabled", 32'(ones), 32'd0);
    rd(1, v); chk("R8 queue untouched", {26'b0, v[21:16]}, 32'd12);
    wr(0, 32'h2200_0800);
    idle(128 * 3);
    // R4 one-shot flush
    wr(0, 32'h2000_0000);
    for (int i = 0; i < 5; i++) wr(2, samp(i + 80));
    rd(1, v); chk("R3 free after five pushes", {26'b0, v[21:16]}, 32'd11);
    wr(1, 32'h100);
    rd(1, v); chk("R4 flush empties queue", v, 32'h0010_0000);
    // R4 held soft reset
    wr(0, 32'h2200_0000);
    for (int i = 0; i < 3; i++) wr(2, samp(i + 90));
    idle(20);
    wr(0, 32'hA200_0000);
    wr(2, samp(99));
    idle(4);
    rd(1, v); chk("R4 soft reset holds queue empty", {26'b0, v[21:16]}, 32'd16);
    chk("R4 soft reset idles link", {29'b0, bclk_o, ws_o, sd_o}, 32'd0);
    // standard framing again, threshold 8
    wr(0, 32'h2000_0000);
    for (int i = 0; i < 17; i++) wr(2, samp(i + 120));
    wr(1, 32'h2); wr(0, 32'h2200_0002);
    idle(600);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule